// File: doc/BRIEF.md
# Shared Receive Character Silo

This block gathers received characters from up to eight serial receivers into one shared first-in first-out store. A receiver hands over a character together with its line number, its length code and three error flags. The block trims the character to its configured length, tags it, and queues it. Software reads a single 16-bit word. That word shows the oldest queued character, and a read strobe retires it so the next one moves up.

Two status flags come out of the block. The done flag is high whenever anything is queued. The alarm flag rises each time a fresh batch of sixteen characters has been accepted. A mode bit chooses which of the two flags raises the receive interrupt. A clear input empties the store, and so does dropping the scan enable. A character offered while the store is full is lost, and the next character that is accepted carries the overrun mark.

Top module: `rx_silo`

## Requirements
- R1: The read word holds the character in bits 7:0, the line number in bits 10:8, a zero in bit 11, parity error in bit 12, framing error in bit 13, overrun in bit 14 and the valid flag in bit 15.
- R2: A read strobe retires the oldest entry, so entries come out in arrival order. A strobe while the store is empty leaves the read word unchanged.
- R3: The valid bit and `rx_done` are 1 exactly when the store holds at least one entry.
- R4: `rx_alarm` rises on the clock edge that accepts the 16th, 32nd, 48th and later multiples of 16 entries counted since the last flush. Pushes that are dropped do not count.
- R5: A read strobe or a flush clears `rx_alarm`. If the same edge also accepts the entry that completes a batch, the alarm is set.
- R6: `irq` is 0 when `rx_ie` is 0. When `rx_ie` is 1 and `alarm_en` is 0, `irq` follows `rx_done`. When both are 1, `irq` follows `rx_alarm` only.
- R7: While `scan_en` is 0 the store stays empty, pushes are dropped and the alarm batch count restarts.
- R8: After `clr` the valid bit reads 0. Bits 14:0 keep the last entry that was presented while the store was non-empty (all zero after reset).
- R9: The length code `push_len` (0, 1, 2, 3 meaning 5, 6, 7, 8 bits) forces the character bits above the chosen length to zero.
- R10: The `push_ovr` input is stored as bit 14 of its own entry.
- R11: The store holds 64 entries. A push into a full store is dropped, and the next accepted entry has bit 14 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | A receiver offers one character this cycle |
| push_char | input | 8 | Received character, right justified |
| push_line | input | 3 | Line that received the character |
| push_len | input | 2 | Character length code (0..3 for 5..8 bits) |
| push_perr | input | 1 | Parity error on this character |
| push_ferr | input | 1 | Framing error on this character |
| push_ovr | input | 1 | This line lost a character before this one |
| rd_strobe | input | 1 | Read of the receive word; retires the oldest entry |
| scan_en | input | 1 | Master enable; 0 holds the store empty |
| clr | input | 1 | Empties the store and restarts the alarm count |
| rx_ie | input | 1 | Receive interrupt enable |
| alarm_en | input | 1 | Interrupt on the alarm instead of on done |
| rd_word | output | 16 | Oldest entry with its valid flag |
| rx_done | output | 1 | Store not empty |
| rx_alarm | output | 1 | Batch-of-sixteen alarm flag |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with its default depth of 64 and batch size of 16. With these values a single fill of 66 back-to-back pushes is enough to see four alarm batches, a full store, two dropped characters and the overrun mark on the next accepted entry. A queue-based model predicts the read word, both flags and the interrupt on every clock. Directed checks cover each length code, reading the store until it is empty, a clear while data is still stored, and switching between the two interrupt modes.

// File: rtl/rx_silo_pkg.sv
package rx_silo_pkg;
  localparam int LINE_W  = 3;
  localparam int CHAR_W  = 8;
  localparam int ENTRY_W = CHAR_W + LINE_W + 4;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic              spare;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] chr;
  } silo_entry_t;

  // length code 0..3 keeps the low 5..8 bits
  function automatic logic [CHAR_W-1:0] trim_char(input logic [CHAR_W-1:0] c,
                                                   input logic [1:0] len);
    logic [1:0]        sh;
    logic [CHAR_W-1:0] m;
    sh = 2'd3 - len;
    m  = {CHAR_W{1'b1}} >> sh;
    return c & m;
  endfunction
endpackage

// File: rtl/rx_silo_store.sv
module rx_silo_store #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop_req,
  output logic [WIDTH-1:0] head,
  output logic             nonempty,
  output logic             full,
  output logic             accepted
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic             pop;

  assign full     = (count == CW'(DEPTH));
  assign nonempty = (count != '0);
  assign accepted = push & ~full & ~flush;
  assign pop      = pop_req & nonempty & ~flush;

  // storage without reset so that it maps onto RAM
  always_ff @(posedge clk) begin
    if (accepted) mem[wr_ptr] <= wdata;
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (accepted) wr_ptr <= wr_ptr + 1'b1;
      if (pop)      rd_ptr <= rd_ptr + 1'b1;
      count <= count + CW'(accepted) - CW'(pop);
    end
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  p_full_drop_r11: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop_req && !flush) |=> $stable(count));

  p_pop_dec_r2: assert property (@(posedge clk) disable iff (rst)
    (pop_req && nonempty && !push && !flush) |=> (count == $past(count) - 1'b1));

  p_flush_empty_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> !nonempty);
endmodule

// File: rtl/rx_silo_alarm.sv
module rx_silo_alarm #(
  parameter int BLOCK = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic accepted,
  input  logic rd,
  output logic alarm
);
  localparam int CW = $clog2(BLOCK);

  logic [CW-1:0] cnt;
  logic          hit;

  assign hit = accepted && (cnt == CW'(BLOCK - 1));

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt   <= '0;
      alarm <= 1'b0;
    end else begin
      if (accepted) cnt <= hit ? '0 : cnt + 1'b1;
      if (hit)      alarm <= 1'b1;
      else if (rd)  alarm <= 1'b0;
    end
  end

  p_alarm_rd_r5: assert property (@(posedge clk) disable iff (rst)
    (rd && !accepted && !flush) |=> !alarm);

  p_alarm_flush_r5: assert property (@(posedge clk) disable iff (rst)
    flush |=> !alarm);

  p_alarm_needs_entry_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm) |-> $past(accepted));
endmodule

// File: rtl/rx_silo.sv
module rx_silo
  import rx_silo_pkg::*;
#(
  parameter int DEPTH       = 64,
  parameter int ALARM_BLOCK = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        push,
  input  logic [7:0]  push_char,
  input  logic [2:0]  push_line,
  input  logic [1:0]  push_len,
  input  logic        push_perr,
  input  logic        push_ferr,
  input  logic        push_ovr,
  input  logic        rd_strobe,
  input  logic        scan_en,
  input  logic        clr,
  input  logic        rx_ie,
  input  logic        alarm_en,
  output logic [15:0] rd_word,
  output logic        rx_done,
  output logic        rx_alarm,
  output logic        irq
);
  logic               flush;
  silo_entry_t        ent;
  logic [ENTRY_W-1:0] head, hold_q;
  logic               nonempty, full, accepted, alarm, pend_ovr;

  assign flush = clr | ~scan_en;

  always_comb begin
    ent.chr   = trim_char(push_char, push_len);
    ent.line  = push_line;
    ent.spare = 1'b0;
    ent.perr  = push_perr;
    ent.ferr  = push_ferr;
    ent.ovr   = push_ovr | pend_ovr;
  end

  rx_silo_store #(.DEPTH(DEPTH), .WIDTH(ENTRY_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .push     (push),
    .wdata    (ent),
    .pop_req  (rd_strobe),
    .head     (head),
    .nonempty (nonempty),
    .full     (full),
    .accepted (accepted)
  );

  rx_silo_alarm #(.BLOCK(ALARM_BLOCK)) u_alarm (
    .clk      (clk),
    .rst      (rst),
    .flush    (flush),
    .accepted (accepted),
    .rd       (rd_strobe),
    .alarm    (alarm)
  );

  // a character lost at the full store marks the next accepted one
  always_ff @(posedge clk) begin
    if (rst || flush)       pend_ovr <= 1'b0;
    else if (push && full)  pend_ovr <= 1'b1;
    else if (accepted)      pend_ovr <= 1'b0;
  end

  // last presented entry, shown with valid low once the store drains
  always_ff @(posedge clk) begin
    if (rst)           hold_q <= '0;
    else if (nonempty) hold_q <= head;
  end

  assign rd_word  = nonempty ? {1'b1, head} : {1'b0, hold_q};
  assign rx_done  = nonempty;
  assign rx_alarm = alarm;
  assign irq      = rx_ie & (alarm_en ? alarm : nonempty);

  p_clr_invalid_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> !rd_word[15]);

  p_spare_zero_r1: assert property (@(posedge clk) disable iff (rst)
    rd_word[15] |-> !rd_word[11]);

  p_alarm_mode_r6: assert property (@(posedge clk) disable iff (rst)
    (alarm_en && !rx_alarm) |-> !irq);

  p_ovr_mark_r11: assert property (@(posedge clk) disable iff (rst)
    (push && full && !flush) |=> pend_ovr);
endmodule

// File: tb/sim_rx_silo.sv
module sim_rx_silo;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        push = 1'b0;
  logic [7:0]  push_char = '0;
  logic [2:0]  push_line = '0;
  logic [1:0]  push_len = '0;
  logic        push_perr = 1'b0, push_ferr = 1'b0, push_ovr = 1'b0;
  logic        rd_strobe = 1'b0, scan_en = 1'b0, clr = 1'b0;
  logic        rx_ie = 1'b0, alarm_en = 1'b0;
  logic [15:0] rd_word;
  logic        rx_done, rx_alarm, irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit started = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  rx_silo u0 (.*);

  // reference model state
  logic [14:0] mq[$];
  logic [14:0] m_hold = '0;
  int          m_cnt16 = 0;
  logic        m_alarm = 1'b0;
  logic        m_povr = 1'b0;

  function automatic logic [7:0] keep_bits(input logic [7:0] c, input logic [1:0] len);
    case (len)
      2'd0:    return {3'b000, c[4:0]};
      2'd1:    return {2'b00, c[5:0]};
      2'd2:    return {1'b0, c[6:0]};
      default: return c;
    endcase
  endfunction

  always @(posedge clk) begin
    logic set_a;
    started = 1;
    if (rst) begin
      mq.delete(); m_hold = '0; m_cnt16 = 0; m_alarm = 0; m_povr = 0;
    end else begin
      if (mq.size() != 0) m_hold = mq[0];
      if (clr || !scan_en) begin
        mq.delete(); m_cnt16 = 0; m_alarm = 0; m_povr = 0;
      end else begin
        int sz;
        sz = mq.size();
        set_a = 0;
        if (rd_strobe && sz != 0) void'(mq.pop_front());
        if (push) begin
          if (sz == 64) m_povr = 1;
          else begin
            mq.push_back({push_ovr | m_povr, push_ferr, push_perr, 1'b0,
                          push_line, keep_bits(push_char, push_len)});
            m_povr = 0;
            m_cnt16++;
            if (m_cnt16 == 16) begin m_cnt16 = 0; set_a = 1; end
          end
        end
        if (rd_strobe) m_alarm = 0;
        if (set_a)     m_alarm = 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-clock comparison, away from the edge
  always begin
    @(posedge clk);
    #2;
    if (started && !finished) begin
      logic        ne;
      logic [15:0] ew;
      ne = (mq.size() != 0);
      ew = ne ? {1'b1, mq[0]} : {1'b0, m_hold};
      chk("R1 word", rd_word, ew);
      chk("R3 done", {15'd0, rx_done}, {15'd0, ne});
      chk("R4 alarm", {15'd0, rx_alarm}, {15'd0, m_alarm});
      chk("R6 irq", {15'd0, irq}, {15'd0, rx_ie & (alarm_en ? m_alarm : ne)});
    end
  end

  task automatic drv(input logic p, input logic [7:0] c, input logic [2:0] l,
                     input logic [1:0] ln, input logic pe, input logic fe,
                     input logic ov, input logic rd);
    @(negedge clk);
    push = p; push_char = c; push_line = l; push_len = ln;
    push_perr = pe; push_ferr = fe; push_ovr = ov; rd_strobe = rd; clr = 1'b0;
  endtask

  task automatic idle();
    drv(1'b0, 8'h00, 3'd0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic settle();
    @(posedge clk);
    #3;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    settle();
    chk("reset word", rd_word, 16'h0000);
    chk("reset irq", {15'd0, irq}, 16'h0000);

    @(negedge clk); scan_en = 1'b1; rx_ie = 1'b1; alarm_en = 1'b0;
    drv(1, 8'hA5, 3'd3, 2'd3, 1, 0, 0, 0);
    idle(); settle();
    chk("R1 layout", rd_word, 16'h93A5);
    chk("R6 irq on done", {15'd0, irq}, 16'h0001);

    drv(1, 8'hFF, 3'd7, 2'd0, 0, 1, 0, 1);
    idle(); settle();
    chk("R9 trim 5 bits", rd_word, 16'hA71F);
    chk("R2 pop order", rd_word[7:0], 16'h001F);

    drv(1, 8'h55, 3'd0, 2'd3, 0, 0, 1, 1);
    idle(); settle();
    chk("R10 overrun in", rd_word, 16'hC055);

    drv(0, 8'h00, 3'd0, 2'd3, 0, 0, 0, 1);
    idle(); settle();
    chk("R3 empty valid", rd_word, 16'h4055);
    chk("R3 done low", {15'd0, rx_done}, 16'h0000);

    drv(0, 8'h00, 3'd0, 2'd3, 0, 0, 0, 1);
    idle(); settle();
    chk("R2 empty read", rd_word, 16'h4055);

    drv(1, 8'h11, 3'd1, 2'd3, 0, 0, 0, 0);
    drv(1, 8'h22, 3'd2, 2'd3, 0, 0, 0, 0);
    idle(); settle();
    chk("R1 head", rd_word, 16'h8111);
    @(negedge clk); clr = 1'b1;
    idle(); settle();
    chk("R8 clr keeps bits", rd_word, 16'h0111);

    for (int i = 0; i < 15; i++)
      drv(1, 8'hA0 + 8'(i), 3'(i), 2'(i), 0, 0, 0, 0);
    idle(); settle();
    chk("R4 no alarm at 15", {15'd0, rx_alarm}, 16'h0000);
    drv(1, 8'hEF, 3'd6, 2'd2, 0, 0, 0, 0);
    idle(); settle();
    chk("R4 alarm at 16", {15'd0, rx_alarm}, 16'h0001);
    chk("R6 done mode", {15'd0, irq}, 16'h0001);
    @(negedge clk); alarm_en = 1'b1;
    settle();
    chk("R6 alarm mode", {15'd0, irq}, 16'h0001);

    drv(0, 8'h00, 3'd0, 2'd3, 0, 0, 0, 1);
    idle(); settle();
    chk("R5 read clears", {15'd0, rx_alarm}, 16'h0000);
    chk("R6 alarm mode off", {15'd0, irq}, 16'h0000);

    @(negedge clk); scan_en = 1'b0;
    drv(1, 8'h77, 3'd4, 2'd3, 0, 0, 0, 0);
    idle(); settle();
    chk("R7 held empty", {15'd0, rx_done}, 16'h0000);
    chk("R7 valid low", {15'd0, rd_word[15]}, 16'h0000);
    @(negedge clk); scan_en = 1'b1; alarm_en = 1'b0;

    for (int i = 0; i < 66; i++)
      drv(1, 8'(i), 3'(i), 2'd3, 0, 0, 0, 0);
    idle(); settle();
    chk("R4 alarm after fill", {15'd0, rx_alarm}, 16'h0001);
    chk("R11 full head", rd_word, 16'h8000);
    drv(0, 8'h00, 3'd0, 2'd3, 0, 0, 0, 1);
    drv(1, 8'hEE, 3'd5, 2'd3, 0, 0, 0, 0);
    for (int i = 0; i < 63; i++)
      drv(0, 8'h00, 3'd0, 2'd3, 0, 0, 0, 1);
    idle(); settle();
    chk("R11 overrun mark", rd_word, 16'hC5EE);
    drv(0, 8'h00, 3'd0, 2'd3, 0, 0, 0, 1);
    idle(); settle();
    chk("R3 drained", rd_word, 16'h45EE);

    repeat (2) @(negedge clk);
    finished = 1;
    summary();
    $finish;
  end
endmodule